// File: doc/BRIEF.md
# Message Bus Initiator Transmitter

This block is the send side of a shared 32-bit synchronous message bus. A local source hands it one message at a time as a stream of words with a valid/ready handshake. The first word is the header, the source marks the final word, and with the header it says whether the message is a data message (a forwarded frame, sent at high priority) or a command message (low priority). A data message always ends with a receive status word.

The block requests the bus on its own active-low request line. For a data message it also pulls the shared active-low high-priority request line. It does not touch the bus until the arbiter's active-low grant arrives. It then drives the envelope, the data words, initiator-ready and end-of-frame from registers. A cycle in which the source has no word becomes a wait state with initiator-ready low.

A target can pull the active-low abort line during the transfer. When that happens the block lets go of the envelope on the next cycle and gives a one-cycle abort pulse. It then reads and discards the rest of that message from the source. The pads are outside the block: one drive-enable output covers the envelope, data, initiator-ready and end-of-frame. The high-priority line is an open-drain pull output.

Top module: `msgbus_tx`

## Requirements
- R1: After reset the bus request is high and the high-priority pull is 0. The drive enable is 0, the envelope is high, source-ready is 0 and the abort pulse is 0.
- R2: When a message is pending, the bus request goes low. No source word is taken and the bus is not driven before the grant input has been seen low.
- R3: The high-priority pull is 1 together with the request only for messages whose priority flag was 1 on the header. It stays 0 for command messages.
- R4: The envelope goes low in the cycle the header is shown and stays low without a gap until the cycle showing the last word. The words appear in source order, and there is exactly one envelope per message.
- R5: Every cycle inside the envelope in which the source had no word ready shows initiator-ready low. A word is valid on the bus only when initiator-ready is high.
- R6: End-of-frame is low only together with the final (status) word of a high-priority message. It is never low for a command message or on a wait cycle.
- R7: When the abort line is seen low while the envelope is low, the envelope is high in the next cycle and the abort pulse is 1 for exactly that one cycle.
- R8: After an abort, the remaining words of the aborted message are taken from the source and discarded. The next message goes out complete and uncorrupted.
- R9: The request line goes high, and the high-priority pull goes to 0, in the same cycle that the envelope goes high. The envelope is never low while the request is high.
- R10: The drive enable is 1 exactly in the cycles in which the envelope is low.
- R11: In the default configuration, the data bus holds the last word sent during a wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Source has a word at its head |
| src_data | input | DATA_W | Source word |
| src_last | input | 1 | Source word is the final word of its message |
| src_hipri | input | 1 | Data message / high priority, sampled with the header |
| src_ready | output | 1 | Block takes the head word this cycle |
| arb_req_n | output | 1 | Own bus request, active low |
| hp_req_pull | output | 1 | Pulls the shared high-priority request line low |
| arb_gnt_n | input | 1 | Bus grant, active low |
| tgt_abort_n | input | 1 | Target abort, active low |
| bus_data | output | DATA_W | Driven data word |
| bus_env_n | output | 1 | Message envelope, active low |
| bus_irdy | output | 1 | Initiator ready, active high |
| bus_eof_n | output | 1 | End of frame, active low |
| bus_drive | output | 1 | Drive enable for envelope, data, ready and end-of-frame pads |
| abort_pulse | output | 1 | One-cycle report of an aborted message |

## Verification
The messages used are:
- a back-to-back command message, which exposes any wait state or end-of-frame the block invents;
- a data message with idle gaps inserted between words, which checks that initiator-ready tracks the source, that the data bus holds its last word during waits, and that end-of-frame lands only on the status word;
- a one-word data message, where the header is also the status word.

Two abort cases are tried: one mid-message and one on the final displayed word. Each is followed by a fresh message, which shows whether the flush left stray words behind. A delayed grant is used throughout to show that no word leaves the source early.

// File: rtl/mbt_pkg.sv
`timescale 1ns/1ps
package mbt_pkg;

   // Sequencer states of the initiator
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,   // nothing pending
      ST_REQ   = 3'd1,   // request raised, waiting for grant
      ST_XFER  = 3'd2,   // owning the bus, taking words
      ST_DRAIN = 3'd3,   // last word on the bus, release next
      ST_FLUSH = 3'd4    // discarding the tail of an aborted message
   } mbt_state_e;

endpackage

// File: rtl/mbt_seq.sv
`timescale 1ns/1ps
module mbt_seq
   import mbt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_valid,
   input  logic       src_last,
   input  logic       src_hipri,
   input  logic       gnt_n,
   input  logic       abort_seen,
   output mbt_state_e state,
   output logic       hipri,
   output logic       src_ready,
   output logic       accept
);

   mbt_state_e state_q, state_d;
   logic       hipri_q;
   logic       last_take;

   assign src_ready = (state_q == ST_XFER) || (state_q == ST_FLUSH);
   assign accept    = src_ready && src_valid;
   assign last_take = accept && src_last;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (src_valid) state_d = ST_REQ;
         ST_REQ:   if (!gnt_n) state_d = ST_XFER;
         ST_XFER: begin
            if (abort_seen)     state_d = last_take ? ST_IDLE : ST_FLUSH;
            else if (last_take) state_d = ST_DRAIN;
         end
         ST_DRAIN: state_d = ST_IDLE;
         ST_FLUSH: if (last_take) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hipri_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && src_valid) hipri_q <= src_hipri;
      end
   end

   assign state = state_q;
   assign hipri = hipri_q;

   AST_GRANT_BEFORE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_REQ && state_q == ST_XFER) |-> !$past(gnt_n)); // R2

   AST_NO_TAKE_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REQ || state_q == ST_IDLE) |-> !accept); // R2

   AST_FLUSH_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLUSH && last_take) |=> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/mbt_bus_drv.sv
`timescale 1ns/1ps
module mbt_bus_drv
   import mbt_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit WAIT_ZERO = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  mbt_state_e        state,
   input  logic              accept,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_last,
   input  logic              hipri,
   input  logic              abort_n,
   output logic              env,
   output logic              irdy,
   output logic              eof,
   output logic [DATA_W-1:0] data,
   output logic              abort_seen,
   output logic              abort_pulse
);

   logic              env_q, irdy_q, eof_q, abort_q;
   logic              load, in_xfer;
   logic [DATA_W-1:0] data_q;

   assign abort_seen = env_q && !abort_n;
   assign in_xfer    = (state == ST_XFER);
   assign load       = in_xfer && accept && !abort_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         env_q   <= 1'b0;
         irdy_q  <= 1'b0;
         eof_q   <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         abort_q <= abort_seen;
         if (load) begin
            env_q  <= 1'b1;
            irdy_q <= 1'b1;
            eof_q  <= src_last && hipri;
         end else if (in_xfer && !abort_seen) begin
            irdy_q <= 1'b0;
            eof_q  <= 1'b0;
         end else begin
            env_q  <= 1'b0;
            irdy_q <= 1'b0;
            eof_q  <= 1'b0;
         end
      end
   end

   generate
      if (WAIT_ZERO) begin : g_wait_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    data_q <= '0;
            else if (load) data_q <= src_data;
            else           data_q <= '0;
         end
      end else begin : g_wait_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    data_q <= '0;
            else if (load) data_q <= src_data;
         end
      end
   endgenerate

   assign env         = env_q;
   assign irdy        = irdy_q;
   assign eof         = eof_q;
   assign data        = data_q;
   assign abort_pulse = abort_q;

   AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      abort_seen |=> (!env_q && abort_q)); // R7

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |=> !abort_q); // R7

   AST_EOF_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      eof_q |-> (irdy_q && env_q)); // R6

   AST_WAIT_INSIDE_ENV: assert property (@(posedge clk) disable iff (!rst_n)
      (env_q && !irdy_q) |-> $past(env_q)); // R5

endmodule

// File: rtl/mbt_req_lines.sv
`timescale 1ns/1ps
module mbt_req_lines
   import mbt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  mbt_state_e state,
   input  logic       hipri,
   input  logic       env,
   output logic       req_n,
   output logic       hp_pull
);

   logic active;

   assign active  = (state == ST_REQ) || (state == ST_XFER) || (state == ST_DRAIN);
   assign req_n   = !active;
   assign hp_pull = active && hipri;

   AST_ENV_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      env |-> !req_n); // R9

   AST_REQ_DROPS_WITH_ENV: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(env) |-> (req_n && !hp_pull)); // R9

endmodule

// File: rtl/msgbus_tx.sv
`timescale 1ns/1ps
module msgbus_tx
   import mbt_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit WAIT_ZERO = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_last,
   input  logic              src_hipri,
   output logic              src_ready,
   output logic              arb_req_n,
   output logic              hp_req_pull,
   input  logic              arb_gnt_n,
   input  logic              tgt_abort_n,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_env_n,
   output logic              bus_irdy,
   output logic              bus_eof_n,
   output logic              bus_drive,
   output logic              abort_pulse
);

   generate
      if (DATA_W < 8 || DATA_W > 128) begin : g_bad_width
         $error("msgbus_tx: DATA_W must be 8..128");
      end
   endgenerate

   mbt_state_e state;
   logic       hipri, accept, abort_seen, env, eof;

   mbt_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_valid  (src_valid),
      .src_last   (src_last),
      .src_hipri  (src_hipri),
      .gnt_n      (arb_gnt_n),
      .abort_seen (abort_seen),
      .state      (state),
      .hipri      (hipri),
      .src_ready  (src_ready),
      .accept     (accept)
   );

   mbt_bus_drv #(
      .DATA_W    (DATA_W),
      .WAIT_ZERO (WAIT_ZERO)
   ) u_drv (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .accept      (accept),
      .src_data    (src_data),
      .src_last    (src_last),
      .hipri       (hipri),
      .abort_n     (tgt_abort_n),
      .env         (env),
      .irdy        (bus_irdy),
      .eof         (eof),
      .data        (bus_data),
      .abort_seen  (abort_seen),
      .abort_pulse (abort_pulse)
   );

   mbt_req_lines u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .hipri   (hipri),
      .env     (env),
      .req_n   (arb_req_n),
      .hp_pull (hp_req_pull)
   );

   assign bus_env_n = !env;
   assign bus_eof_n = !eof;
   assign bus_drive = env;

endmodule

// File: tb/msgbus_tx_bench.sv
`timescale 1ns/1ps
module msgbus_tx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_valid = 1'b0;
   logic [31:0] src_data = '0;
   logic        src_last = 1'b0;
   logic        src_hipri = 1'b0;
   logic        src_ready;
   logic        arb_req_n, hp_req_pull;
   logic        arb_gnt_n = 1'b1;
   logic        tgt_abort_n = 1'b1;
   logic [31:0] bus_data;
   logic        bus_env_n, bus_irdy, bus_eof_n, bus_drive, abort_pulse;

   always #2 clk = ~clk;   // 250 MHz

   msgbus_tx u_msgbus_tx (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
      .src_last(src_last), .src_hipri(src_hipri), .src_ready(src_ready),
      .arb_req_n(arb_req_n), .hp_req_pull(hp_req_pull), .arb_gnt_n(arb_gnt_n),
      .tgt_abort_n(tgt_abort_n), .bus_data(bus_data), .bus_env_n(bus_env_n),
      .bus_irdy(bus_irdy), .bus_eof_n(bus_eof_n), .bus_drive(bus_drive),
      .abort_pulse(abort_pulse)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // monitor state
   bit          mon_on = 1'b0;
   logic [31:0] words [0:15];
   int cnt, eof_idx, eof_bad, waits, hold_bad, env_starts, rel_bad, drive_bad;
   int env_wo_req, hp_seen, hp_bad, pregnt_bad, pulses, abort_at, abort_ok;
   int gnt_age;
   bit gnt_seen, prev_env, abort_armed, abort_done;
   logic [31:0] last_word;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_mon(input int ab);
      cnt = 0; eof_idx = -1; eof_bad = 0; waits = 0; hold_bad = 0; env_starts = 0;
      rel_bad = 0; drive_bad = 0; env_wo_req = 0; hp_seen = 0; hp_bad = 0;
      pregnt_bad = 0; pulses = 0; abort_at = ab; abort_ok = 0;
      abort_armed = 0; abort_done = 0; last_word = '0;
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (bus_drive != !bus_env_n) drive_bad++;
         if (!bus_env_n) begin
            if (prev_env) env_starts++;
            if (arb_req_n) env_wo_req++;
            if (!gnt_seen) pregnt_bad++;
            if (bus_irdy) begin
               if (cnt < 16) words[cnt] = bus_data;
               if (!bus_eof_n) eof_idx = cnt;
               last_word = bus_data;
               cnt++;
            end else begin
               waits++;
               if (!bus_eof_n) eof_bad++;
               if (bus_data != last_word) hold_bad++;
            end
         end else if (!prev_env) begin
            if (!arb_req_n || hp_req_pull) rel_bad++;
         end
         if (hp_req_pull) begin
            if (arb_req_n) hp_bad++; else hp_seen++;
         end
         if (src_ready && !arb_req_n && !gnt_seen) pregnt_bad++;
         if (abort_pulse) pulses++;
         // abort injection
         if (abort_armed) begin
            if (bus_env_n && abort_pulse) abort_ok++;
            abort_armed = 0;
            tgt_abort_n = 1'b1;
         end else if (abort_at >= 0 && !abort_done && !bus_env_n && cnt == abort_at) begin
            tgt_abort_n = 1'b0;
            abort_armed = 1;
            abort_done  = 1;
         end
         prev_env = bus_env_n;
      end
      // grant generator: grant after request has been low for 3 samples
      if (arb_req_n) begin
         gnt_age = 0; arb_gnt_n = 1'b1; gnt_seen = 0;
      end else begin
         gnt_age++;
         if (gnt_age >= 3) begin arb_gnt_n = 1'b0; gnt_seen = 1; end
      end
   end

   function automatic logic [31:0] wval(input int m, input int i);
      return 32'hA500_0000 + m * 256 + i;
   endfunction

   // drive one message; gapmask bit i (i>0) inserts one idle cycle before word i
   task automatic send(input int m, input int n, input bit hp, input int gapmask);
      for (int i = 0; i < n; i++) begin
         bit got;
         if (i > 0 && gapmask[i]) begin
            @(negedge clk); src_valid = 1'b0;
         end
         @(negedge clk);
         src_valid = 1'b1; src_data = wval(m, i); src_last = (i == n - 1); src_hipri = hp;
         got = 0;
         while (!got) begin
            #1 got = src_ready;
            if (!got) @(negedge clk);
         end
      end
      @(negedge clk);
      src_valid = 1'b0; src_last = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (!arb_req_n || !bus_env_n) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_words(input int m, input int n, input string tag);
      int bad = 0;
      for (int i = 0; i < n && i < 16; i++) if (words[i] !== wval(m, i)) bad++;
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic t_reset();
      #1;
      chk(arb_req_n == 1'b1, "R1 request idle", arb_req_n, 1);
      chk(hp_req_pull == 1'b0, "R1 hp pull idle", hp_req_pull, 0);
      chk(bus_drive == 1'b0, "R1 drive idle", bus_drive, 0);
      chk(bus_env_n == 1'b1, "R1 envelope idle", bus_env_n, 1);
      chk(src_ready == 1'b0, "R1 ready idle", src_ready, 0);
      chk(abort_pulse == 1'b0, "R1 abort pulse idle", abort_pulse, 0);
   endtask

   task automatic t_cmd();
      clr_mon(-1);
      send(1, 4, 1'b0, 0);
      wait_idle();
      chk(pregnt_bad == 0, "R2 no activity before grant (cmd)", pregnt_bad, 0);
      chk(hp_seen == 0 && hp_bad == 0, "R3 no hp pull for command", hp_seen, 0);
      chk(cnt == 4, "R4 command word count", cnt, 4);
      chk_words(1, 4, "R4 command word order");
      chk(env_starts == 1 && waits == 0, "R4 single gapless envelope", env_starts, 1);
      chk(eof_idx == -1 && eof_bad == 0, "R6 no eof on command", eof_idx, -1);
      chk(rel_bad == 0 && env_wo_req == 0, "R9 request released with envelope", rel_bad, 0);
      chk(drive_bad == 0, "R10 drive matches envelope", drive_bad, 0);
   endtask

   task automatic t_data_gaps();
      clr_mon(-1);
      send(2, 6, 1'b1, 32'b0_1010_0);   // gaps before words 2 and 4
      wait_idle();
      chk(pregnt_bad == 0, "R2 no activity before grant (data)", pregnt_bad, 0);
      chk(hp_seen > 0 && hp_bad == 0, "R3 hp pull for data message", hp_seen, 1);
      chk(cnt == 6, "R4 data word count", cnt, 6);
      chk_words(2, 6, "R4 data word order");
      chk(env_starts == 1, "R4 envelope continuous over waits", env_starts, 1);
      chk(waits == 2, "R5 wait states match source gaps", waits, 2);
      chk(eof_idx == 5 && eof_bad == 0, "R6 eof with status word", eof_idx, 5);
      chk(hold_bad == 0, "R11 data held during wait", hold_bad, 0);
      chk(rel_bad == 0 && env_wo_req == 0, "R9 release with hp pull", rel_bad, 0);
      chk(drive_bad == 0, "R10 drive over waits", drive_bad, 0);
   endtask

   task automatic t_single();
      clr_mon(-1);
      send(3, 1, 1'b1, 0);
      wait_idle();
      chk(cnt == 1, "R4 single word count", cnt, 1);
      chk_words(3, 1, "R4 single word value");
      chk(eof_idx == 0, "R6 eof on one-word data message", eof_idx, 0);
   endtask

   task automatic t_abort_mid();
      clr_mon(3);
      send(4, 8, 1'b1, 0);
      wait_idle();
      chk(cnt == 3, "R7 words shown before abort", cnt, 3);
      chk(abort_ok == 1, "R7 envelope released next cycle with pulse", abort_ok, 1);
      chk(pulses == 1, "R7 single abort pulse", pulses, 1);
      chk(eof_idx == -1, "R7 no eof on aborted message", eof_idx, -1);
      chk(rel_bad == 0 && env_wo_req == 0, "R9 request released on abort", rel_bad, 0);
      chk(src_ready == 1'b0, "R8 flush finished, back to idle", src_ready, 0);
      clr_mon(-1);
      send(5, 3, 1'b0, 32'b010);
      wait_idle();
      chk(cnt == 3, "R8 next message count after flush", cnt, 3);
      chk_words(5, 3, "R8 next message clean after flush");
      chk(pulses == 0, "R8 no stray abort pulse", pulses, 0);
   endtask

   task automatic t_abort_last();
      clr_mon(4);
      send(6, 4, 1'b1, 0);
      wait_idle();
      chk(cnt == 4, "R7 all words shown before late abort", cnt, 4);
      chk(abort_ok == 1, "R7 late abort releases and pulses", abort_ok, 1);
      chk(pulses == 1, "R7 late abort single pulse", pulses, 1);
      clr_mon(-1);
      send(7, 2, 1'b1, 0);
      wait_idle();
      chk_words(7, 2, "R8 message after late abort");
      chk(eof_idx == 1, "R6 eof after late abort", eof_idx, 1);
   endtask

   initial begin
      #(100000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      prev_env = 1'b1;
      mon_on = 1'b1;
      repeat (2) @(negedge clk);
      t_cmd();
      t_data_gaps();
      t_single();
      t_abort_mid();
      t_abort_last();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule